// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number. It reads page table entries from memory through a plain read port. A client hands it one request at a time. Each request carries a virtual address and an access type. The block walks a two-level table and returns one of three results: a physical page number, a page fault or a protection fault. The walk starts from a table base register. Loading that register switches the active address space for every later request. A two-level table costs one extra memory read on every walk, and in return it keeps the storage for unused regions of the address space small.

The page offset passes straight through, and the physical page number from the leaf entry is placed in front of it. The walker holds no translations between requests. Any caching is left to a separate structure.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done`, `mem_rd`, `page_fault` and `prot_fault` are low, and `rsp_ppn` and `rsp_paddr` are zero.
- R2: The block accepts a request on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from that edge up to and including the cycle in which `done` is high. A `req_valid` seen while `busy` is high is ignored: it starts no walk and does not change the result of the walk in progress.
- R3: An entry is 32 bits. Bit 0 is the valid flag. Bits 2:1 are the rights. Bits 31:12 are a page number. The first read goes to address {base, vaddr[31:22], 2'b00}. The second read goes to {first-entry page number, vaddr[21:12], 2'b00}. The rights field of the first-level entry has no effect.
- R4: If the first-level entry has bit 0 clear, the walk ends with `page_fault` high and `prot_fault` low. Exactly one memory read is made.
- R5: If the second-level entry has bit 0 clear, the walk ends with `page_fault` high. On any fault, `rsp_ppn` and `rsp_paddr` are zero.
- R6: The access type `req_acc` is coded 00 read, 01 write, 10 execute and 11 illegal. The rights are coded 00 read-only, 01 read-write, 10 execute-only and 11 reserved. Reads are allowed under 00 and 01. Writes are allowed only under 01. Execution is allowed only under 10. Every other pair of a valid leaf entry and an access type, including rights 11 and access 11, gives `prot_fault` high with `page_fault` low.
- R7: A walk that passes both checks returns the leaf entry's page number on `rsp_ppn`, and `rsp_paddr` = {`rsp_ppn`, vaddr[11:0]}. Both fault flags are low.
- R8: `done` is high for exactly one cycle per accepted request. `rsp_ppn`, `rsp_paddr` and the fault flags change only on the edge that raises `done`, and they hold until the next one.
- R9: A write with `base_we` sets the table base to `base_ppn` for requests accepted afterwards. A walk already accepted keeps using the base in force at its acceptance.
- R10: `mem_rd` is a single-cycle pulse, and `mem_addr` is valid with it. Only one read is outstanding at a time: the next read starts only after `mem_rvalid` returns the previous entry. A successful walk makes exactly two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the table base register |
| base_ppn | input | 20 | Page number of the first-level table |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 illegal |
| busy | output | 1 | A walk is in progress |
| mem_rd | output | 1 | Memory read strobe, one cycle |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | Walk finished, one-cycle pulse |
| rsp_ppn | output | 20 | Translated physical page number |
| rsp_paddr | output | 32 | Translated physical address |
| page_fault | output | 1 | An entry on the walk was invalid |
| prot_fault | output | 1 | The leaf entry forbids the access |

## Verification
The bench checks an invalid first-level entry. A walker that failed to stop would issue a second read from a garbage table address and could return a stale page number. It tries every pair of access type and rights. A wrong permission table shows up as a protection fault on a legal access, or as a translation that should have been refused. It changes the base register in the middle of a walk and pulses a request while the walker is busy. A design that read the live base, or that accepted requests it should not, would return a translation from the wrong address space or raise a second `done`. It also gives the memory random response delays, which exposes any walker that assumes a fixed read latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_ILL   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RT_RO  = 2'b00,
    RT_RW  = 2'b01,
    RT_XO  = 2'b10,
    RT_RSV = 2'b11
  } rights_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE1,
    ST_WAIT1,
    ST_ISSUE2,
    ST_WAIT2,
    ST_FIN
  } walk_state_e;

  function automatic logic access_allowed(input logic [1:0] rights, input logic [1:0] acc);
    logic ok;
    ok = 1'b0;
    case (acc)
      ACC_READ:  ok = (rights == RT_RO) || (rights == RT_RW);
      ACC_WRITE: ok = (rights == RT_RW);
      ACC_EXEC:  ok = (rights == RT_XO);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PPN_W-1:0] wdata,
  output logic [PPN_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (we) begin
      base_q <= wdata;
    end
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W = 20,
  parameter int IDX_W = 10,
  parameter int SH    = 2,
  parameter int PA_W  = 32
) (
  input  logic [PPN_W-1:0] tbl_ppn,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);

  localparam int RAW_W = PPN_W + IDX_W + SH;

  logic [RAW_W-1:0] raw;

  assign raw  = {tbl_ppn, idx, {SH{1'b0}}};
  assign addr = PA_W'(raw);

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int PPN_W   = 20
) (
  input  logic [ENTRY_W-1:0] pte,
  input  logic [1:0]         acc,
  output logic               present,
  output logic               rights_ok,
  output logic [PPN_W-1:0]   ppn
);

  logic [1:0] rights;
  logic       unused_bits;

  assign present     = pte[0];
  assign rights      = pte[2:1];
  assign ppn         = pte[ENTRY_W-1 -: PPN_W];
  assign rights_ok   = access_allowed(rights, acc);
  assign unused_bits = ^pte[ENTRY_W-PPN_W-1:3];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int L1_W    = 10,
  parameter int ENTRY_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 base_we,
  input  logic [PA_W-PAGE_W-1:0] base_ppn,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [1:0]           req_acc,
  output logic                 busy,
  output logic                 mem_rd,
  output logic [PA_W-1:0]      mem_addr,
  input  logic                 mem_rvalid,
  input  logic [ENTRY_W-1:0]   mem_rdata,
  output logic                 done,
  output logic [PA_W-PAGE_W-1:0] rsp_ppn,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 page_fault,
  output logic                 prot_fault
);

  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int L2_W   = VPN_W - L1_W;
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int IDX_SH = $clog2(ENTRY_W / 8);
  localparam int LEVELS = 2;

  walk_state_e state;

  logic [PPN_W-1:0]  base_q;
  logic [PPN_W-1:0]  base_snap;
  logic [PPN_W-1:0]  l2tbl_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PAGE_W-1:0] off_q;
  logic [1:0]        acc_q;

  logic [PPN_W-1:0]  tbl_sel  [LEVELS];
  logic [PA_W-1:0]   lvl_addr [LEVELS];

  logic              ent_present;
  logic              ent_rights_ok;
  logic [PPN_W-1:0]  ent_ppn;

  logic              accept;

  assign accept = req_valid && !busy;

  ptw_base_reg #(.PPN_W(PPN_W)) u_base (
    .clk    (clk),
    .rst    (rst),
    .we     (base_we),
    .wdata  (base_ppn),
    .base_q (base_q)
  );

  assign tbl_sel[0] = base_snap;
  assign tbl_sel[1] = l2tbl_q;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int IW = (lv == 0) ? L1_W : L2_W;
    logic [IW-1:0] idx;
    if (lv == 0) begin : g_dir
      assign idx = vpn_q[VPN_W-1 -: L1_W];
    end else begin : g_leaf
      assign idx = vpn_q[L2_W-1:0];
    end
    ptw_addr_gen #(
      .PPN_W (PPN_W),
      .IDX_W (IW),
      .SH    (IDX_SH),
      .PA_W  (PA_W)
    ) u_ag (
      .tbl_ppn (tbl_sel[lv]),
      .idx     (idx),
      .addr    (lvl_addr[lv])
    );
  end

  ptw_pte_check #(
    .ENTRY_W (ENTRY_W),
    .PPN_W   (PPN_W)
  ) u_chk_pte (
    .pte       (mem_rdata),
    .acc       (acc_q),
    .present   (ent_present),
    .rights_ok (ent_rights_ok),
    .ppn       (ent_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      mem_rd     <= 1'b0;
      mem_addr   <= '0;
      base_snap  <= '0;
      l2tbl_q    <= '0;
      vpn_q      <= '0;
      off_q      <= '0;
      acc_q      <= '0;
      rsp_ppn    <= '0;
      rsp_paddr  <= '0;
      page_fault <= 1'b0;
      prot_fault <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            busy      <= 1'b1;
            base_snap <= base_q;
            vpn_q     <= req_vaddr[VA_W-1:PAGE_W];
            off_q     <= req_vaddr[PAGE_W-1:0];
            acc_q     <= req_acc;
            state     <= ST_ISSUE1;
          end
        end
        ST_ISSUE1: begin
          mem_rd   <= 1'b1;
          mem_addr <= lvl_addr[0];
          state    <= ST_WAIT1;
        end
        ST_WAIT1: begin
          if (mem_rvalid) begin
            if (!ent_present) begin
              done       <= 1'b1;
              page_fault <= 1'b1;
              prot_fault <= 1'b0;
              rsp_ppn    <= '0;
              rsp_paddr  <= '0;
              state      <= ST_FIN;
            end else begin
              l2tbl_q <= ent_ppn;
              state   <= ST_ISSUE2;
            end
          end
        end
        ST_ISSUE2: begin
          mem_rd   <= 1'b1;
          mem_addr <= lvl_addr[1];
          state    <= ST_WAIT2;
        end
        ST_WAIT2: begin
          if (mem_rvalid) begin
            done  <= 1'b1;
            state <= ST_FIN;
            if (!ent_present) begin
              page_fault <= 1'b1;
              prot_fault <= 1'b0;
              rsp_ppn    <= '0;
              rsp_paddr  <= '0;
            end else if (!ent_rights_ok) begin
              page_fault <= 1'b0;
              prot_fault <= 1'b1;
              rsp_ppn    <= '0;
              rsp_paddr  <= '0;
            end else begin
              page_fault <= 1'b0;
              prot_fault <= 1'b0;
              rsp_ppn    <= ent_ppn;
              rsp_paddr  <= {ent_ppn, off_q};
            end
          end
        end
        ST_FIN: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   busy,
  input logic                   mem_rd,
  input logic                   mem_rvalid,
  input logic                   done,
  input logic [PA_W-PAGE_W-1:0] rsp_ppn,
  input logic [PA_W-1:0]        rsp_paddr,
  input logic                   page_fault,
  input logic                   prot_fault
);

  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !mem_rd && !page_fault && !prot_fault));

  // R2
  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R2
  a_r2_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R8
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  a_r8_ppn_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_ppn) |-> done);

  // R8
  a_r8_paddr_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_paddr) |-> done);

  // R10
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R10
  a_r10_rd_in_walk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (busy && !done));

  // R6
  a_r6_faults_exclusive: assert property (@(posedge clk) disable iff (rst)
    done |-> !(page_fault && prot_fault));

  // R5
  a_r5_fault_zero_ppn: assert property (@(posedge clk) disable iff (rst)
    (done && (page_fault || prot_fault)) |-> (rsp_ppn == '0 && rsp_paddr == '0));

endmodule

bind pt_walker pt_walker_checker #(.PA_W(PA_W), .PAGE_W(PAGE_W)) u_walker_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .mem_rd     (mem_rd),
  .mem_rvalid (mem_rvalid),
  .done       (done),
  .rsp_ppn    (rsp_ppn),
  .rsp_paddr  (rsp_paddr),
  .page_fault (page_fault),
  .prot_fault (prot_fault)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [19:0] base_ppn = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        busy;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [19:0] rsp_ppn;
  logic [31:0] rsp_paddr;
  logic        page_fault;
  logic        prot_fault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] bmem [logic [31:0]];
  logic [31:0] addr_hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst), .base_we(base_we), .base_ppn(base_ppn),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .rsp_ppn(rsp_ppn), .rsp_paddr(rsp_paddr),
    .page_fault(page_fault), .prot_fault(prot_fault)
  );

  function automatic logic [31:0] rdmem(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : 32'h0;
  endfunction

  function automatic bit allowed(input logic [1:0] r, input logic [1:0] acc);
    case (acc)
      2'b00:   return (r == 2'b00) || (r == 2'b01);
      2'b01:   return r == 2'b01;
      2'b10:   return r == 2'b10;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk_pte(input logic [19:0] ppn, input logic [1:0] r, input bit v);
    return {ppn, 9'h0, r, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // memory responder with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd) begin
        logic [31:0] a;
        a = mem_addr;
        addr_hist.push_back(a);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = rdmem(a);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = $urandom;
      end
    end
  end

  task automatic set_base(input logic [19:0] b);
    @(negedge clk);
    base_we  = 1'b1;
    base_ppn = b;
    @(negedge clk);
    base_we  = 1'b0;
  endtask

  // one walk, checked against the bench model; optional base write or stray request mid-walk
  task automatic walk(input logic [19:0] base, input logic [31:0] va, input logic [1:0] acc,
                      input bit poke_base, input bit poke_req, input string tag);
    logic [31:0] a1, a2, e1, e2;
    logic [19:0] eppn;
    bit epf, exf;
    int nrd, waitc;
    a1 = {base, va[31:22], 2'b00};
    e1 = rdmem(a1);
    a2 = {e1[31:12], va[21:12], 2'b00};
    e2 = rdmem(a2);
    epf = 0; exf = 0; eppn = '0; nrd = 1;
    if (!e1[0]) epf = 1;
    else begin
      nrd = 2;
      if (!e2[0]) epf = 1;
      else if (!allowed(e2[2:1], acc)) exf = 1;
      else eppn = e2[31:12];
    end
    addr_hist.delete();
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2", {tag, " busy after accept"}, 32'(busy), 32'd1);
    if (poke_base) begin
      base_we = 1'b1; base_ppn = ~base;
      @(negedge clk);
      base_we = 1'b0;
    end
    if (poke_req) begin
      req_valid = 1'b1; req_vaddr = ~va; req_acc = ~acc;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 100) begin
      @(negedge clk);
      waitc++;
    end
    chk(done == 1'b1, "R8", {tag, " done seen"}, 32'(done), 32'd1);
    chk(busy == 1'b1, "R2", {tag, " busy with done"}, 32'(busy), 32'd1);
    chk(page_fault == epf, epf ? "R5" : "R6", {tag, " page_fault"}, 32'(page_fault), 32'(epf));
    chk(prot_fault == exf, "R6", {tag, " prot_fault"}, 32'(prot_fault), 32'(exf));
    chk(rsp_ppn == eppn, "R7", {tag, " ppn"}, 32'(rsp_ppn), 32'(eppn));
    chk(rsp_paddr == ((epf || exf) ? 32'h0 : {eppn, va[11:0]}), "R7", {tag, " paddr"},
        rsp_paddr, (epf || exf) ? 32'h0 : {eppn, va[11:0]});
    chk(addr_hist.size() == nrd, nrd == 1 ? "R4" : "R10", {tag, " read count"},
        32'(addr_hist.size()), 32'(nrd));
    if (addr_hist.size() >= 1) chk(addr_hist[0] == a1, "R3", {tag, " first addr"}, addr_hist[0], a1);
    if (addr_hist.size() >= 2) chk(addr_hist[1] == a2, "R3", {tag, " second addr"}, addr_hist[1], a2);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8", {tag, " done one cycle"}, {30'h0, busy, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2", {tag, " no extra walk"}, {30'h0, busy, done}, 32'h0);
    chk(rsp_ppn == eppn, "R8", {tag, " result held"}, 32'(rsp_ppn), 32'(eppn));
  endtask

  localparam logic [19:0] BASE_A = 20'h00010;
  localparam logic [19:0] BASE_B = 20'h00020;

  task automatic fill_space(input logic [19:0] base);
    for (int hi = 0; hi < 8; hi++) begin
      logic [19:0] tbl;
      tbl = 20'h40000 | (base << 4) | 20'(hi);
      bmem[{base, 10'(hi), 2'b00}] = mk_pte(tbl, 2'($urandom), (hi != 7));
      for (int lo = 0; lo < 16; lo++) begin
        bmem[{tbl, 10'(lo), 2'b00}] = mk_pte(20'($urandom), 2'($urandom), ($urandom_range(0, 3) != 0));
      end
    end
  endtask

  initial begin
    logic [19:0] cur;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_rd == 0, "R1", "reset outputs", {29'h0, busy, done, mem_rd}, 32'h0);
    chk(page_fault == 0 && prot_fault == 0 && rsp_ppn == 0 && rsp_paddr == 0, "R1", "reset results",
        rsp_paddr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_rd == 0, "R1", "after reset", {29'h0, busy, done, mem_rd}, 32'h0);

    fill_space(BASE_A);
    fill_space(BASE_B);

    // directed: every rights x access pair on a valid leaf (R6, R7); L1 rights field set odd (R3)
    set_base(BASE_A);
    bmem[{BASE_A, 10'd100, 2'b00}] = mk_pte(20'h55000, 2'b11, 1'b1);
    for (int r = 0; r < 4; r++) begin
      bmem[{20'h55000, 10'(r), 2'b00}] = mk_pte(20'h0ABC0 + 20'(r), 2'(r), 1'b1);
      for (int a = 0; a < 4; a++) begin
        walk(BASE_A, {10'd100, 10'(r), 12'h5A5}, 2'(a), 0, 0, "R6 rights grid");
      end
    end
    // invalid first level, no second read (R4)
    bmem[{BASE_A, 10'd200, 2'b00}] = 32'hFFFF_FFFE;
    walk(BASE_A, {10'd200, 10'd3, 12'h001}, 2'b00, 0, 0, "R4 invalid dir");
    // invalid leaf (R5)
    bmem[{20'h55000, 10'd9, 2'b00}] = mk_pte(20'hBEEF0, 2'b01, 1'b0);
    walk(BASE_A, {10'd100, 10'd9, 12'hFFF}, 2'b00, 0, 0, "R5 invalid leaf");
    // base write mid-walk ignored by that walk (R9), stray request ignored (R2)
    walk(BASE_A, {10'd100, 10'd1, 12'h123}, 2'b01, 1, 0, "R9 base write in walk");
    set_base(BASE_A);
    walk(BASE_A, {10'd100, 10'd0, 12'h777}, 2'b00, 0, 1, "R2 request while busy");
    // address-space switch (R9)
    set_base(BASE_B);
    walk(BASE_B, {10'd100, 10'd0, 12'h777}, 2'b00, 0, 0, "R9 switched space");

    // random walks over both spaces
    cur = BASE_B;
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        cur = (cur == BASE_A) ? BASE_B : BASE_A;
        set_base(cur);
      end
      walk(cur, {10'($urandom_range(0, 8)), 10'($urandom_range(0, 16)), 12'($urandom)},
           2'($urandom), 0, ($urandom_range(0, 7) == 0), "R7 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule